// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Acknowledge Controller

This block pairs two eight-line priority resolver cores, one acting as master and one as slave, into a sixteen-line interrupt controller. Sources raise or drop requests by global number. Numbers 0 to 7 go to the master and 8 to 15 go to the slave. Any other number has no effect. Each core latches a request on a rising level, so holding a line high does not re-request it. A core reports a pending line when its highest-priority request outranks every line it is already serving. The lowest line number has the highest priority.

The slave does not drive the CPU. A new pending condition on the slave reaches master line 2 as a one-shot edge. The single CPU interrupt output follows the master's pending flag. When the CPU pulses its acknowledge input, the block resolves the master first. If the master's winning line is the cascade line, it then queries and acknowledges the slave. One cycle later it presents an 8-bit vector, built from the vector base of the chip that serviced the acknowledge. An acknowledge that finds nothing pending returns that chip's base plus 7 and marks nothing in service. A per-core end-of-service input retires the highest-priority in-service line.

Top module: `casc_intc`

## Requirements
- R1: A request number n in 0..15 updates the level of core n/8 (0 = master, 1 = slave), line n mod 8.
- R2: A request number of 16 or more changes no core state. Neither the interrupt output nor a later vector is affected.
- R3: `int_out` is high exactly when the master has a pending line. It is low after reset.
- R4: When the slave's pending flag goes from low to high, master line 2 latches a request once, on the following clock edge. A pending flag that stays high does not re-request.
- R5: When an acknowledge finds the master pending on a line other than 2, that line moves from requested to in-service. The vector is the master base (0x20 by default) plus the line.
- R6: When the master's winning line is 2 and the slave is pending, both cores acknowledge their lines. The vector is the slave base (0x28 by default) plus the slave line.
- R7: When the master's winning line is 2 and the slave has nothing pending, the vector is the slave base plus 7. The slave marks no line in service.
- R8: An acknowledge with nothing pending on the master returns the master base plus 7. No line is marked in service.
- R9: `vec_valid` is high in exactly the cycle after an `inta` cycle. `int_out` reflects the post-acknowledge state from that cycle on.
- R10: A request is latched only on a low-to-high level change of its line. Re-asserting a line that is already high does not latch a request.
- R11: An end-of-service pulse to a core clears that core's highest-priority in-service line.
- R12: A core is pending only if its best requested line has a lower number than its best in-service line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request level update strobe |
| req_num | input | NUM_W (5) | Global request number |
| req_level | input | 1 | New level for the addressed line |
| inta | input | 1 | CPU acknowledge pulse |
| eoi_master | input | 1 | End-of-service to master core |
| eoi_slave | input | 1 | End-of-service to slave core |
| int_out | output | 1 | Interrupt request to CPU |
| vec_valid | output | 1 | Vector valid, one cycle after `inta` |
| vector | output | VEC_W (8) | Acknowledge vector |

## Verification
The block is driven with single master requests, with slave requests that must travel through the cascade line, with out-of-range numbers, and with repeated assertion of a line that is already high. These patterns separate correct routing and edge latching from level-sensitive behaviour. Acknowledges are issued with nothing pending, with the cascade line raised only by an external request, and with a real slave request. This separates the master-spurious, slave-spurious and cascaded vector paths. Nested in-service states check that the forwarded edge is held off by an in-service line 2 and released by end-of-service. A behavioural model is compared against the outputs on every cycle.

// File: rtl/casc_pkg.sv
package casc_pkg;
   localparam int CORES     = 2;
   localparam int MASTER_ID = 0;
   localparam int SLAVE_ID  = 1;

   typedef enum logic [1:0] {
      PATH_MSPUR = 2'd0,
      PATH_LOCAL = 2'd1,
      PATH_CASC  = 2'd2,
      PATH_SSPUR = 2'd3
   } ack_path_e;
endpackage

// File: rtl/casc_prio_enc.sv
module casc_prio_enc #(
   parameter int N  = 8,
   parameter int LW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic          any,
   output logic [LW-1:0] idx
);
   always_comb begin
      any = |vec;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = LW'(i);
      end
   end
endmodule

// File: rtl/casc_core.sv
module casc_core #(
   parameter int N  = 8,
   parameter int LW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lvl_we,
   input  logic [LW-1:0] lvl_line,
   input  logic          lvl_val,
   input  logic [N-1:0]  inj,
   input  logic          ack_en,
   input  logic [LW-1:0] ack_line,
   input  logic          eoi,
   output logic          pend,
   output logic [LW-1:0] pend_line
);
   logic [N-1:0]  lvl, irr, isr;
   logic [N-1:0]  set_m, clr_m, eoi_m, irr_nxt, isr_nxt;
   logic          req_any, srv_any;
   logic [LW-1:0] req_idx, srv_idx;

   casc_prio_enc #(.N(N), .LW(LW)) u_req_enc (.vec(irr), .any(req_any), .idx(req_idx));
   casc_prio_enc #(.N(N), .LW(LW)) u_srv_enc (.vec(isr), .any(srv_any), .idx(srv_idx));

   always_comb begin
      set_m = inj;
      if (lvl_we && lvl_val && !lvl[lvl_line]) set_m[lvl_line] = 1'b1;
      clr_m = '0;
      if (ack_en) clr_m[ack_line] = 1'b1;
      eoi_m = '0;
      if (eoi && srv_any) eoi_m[srv_idx] = 1'b1;
      // a fresh edge on the acknowledged line wins over the clear
      irr_nxt = (irr & ~clr_m) | set_m;
      isr_nxt = (isr & ~eoi_m) | clr_m;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl <= '0;
         irr <= '0;
         isr <= '0;
      end else begin
         if (lvl_we) lvl[lvl_line] <= lvl_val;
         irr <= irr_nxt;
         isr <= isr_nxt;
      end
   end

   assign pend      = req_any && (!srv_any || (req_idx < srv_idx));
   assign pend_line = req_idx;

   p_edge_irr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_we && lvl_val && !lvl[lvl_line]) |=> irr[$past(lvl_line)]);
   p_ack_isr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_en |=> isr[$past(ack_line)]);
   p_eoi_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !ack_en && (isr != '0)) |=> ($countones(isr) + 1 == $countones($past(isr))));
   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (irr == '0) |-> !pend);
endmodule

// File: rtl/casc_intc.sv
module casc_intc #(
   parameter int                N         = 8,
   parameter int                NUM_W     = 5,
   parameter int                VEC_W     = 8,
   parameter int                CASC_LINE = 2,
   parameter logic [VEC_W-1:0]  MBASE     = 8'h20,
   parameter logic [VEC_W-1:0]  SBASE     = 8'h28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [NUM_W-1:0] req_num,
   input  logic             req_level,
   input  logic             inta,
   input  logic             eoi_master,
   input  logic             eoi_slave,
   output logic             int_out,
   output logic             vec_valid,
   output logic [VEC_W-1:0] vector
);
   import casc_pkg::*;

   localparam int LW    = $clog2(N);
   localparam int TOTAL = CORES * N;
   localparam logic [VEC_W-1:0] SPUR_OFS = VEC_W'(N - 1);

   if (NUM_W < LW + 1) begin : g_bad_numw
      $error("NUM_W too narrow for %0d lines", TOTAL);
   end
   if ((int'(MBASE) % N) != 0 || (int'(SBASE) % N) != 0) begin : g_bad_base
      $error("vector bases must be aligned to the line count");
   end
   if (CASC_LINE >= N) begin : g_bad_casc
      $error("cascade line out of range");
   end

   logic             core_we   [CORES];
   logic [N-1:0]     core_inj  [CORES];
   logic             core_ack  [CORES];
   logic [LW-1:0]    core_aline[CORES];
   logic             core_eoi  [CORES];
   logic             core_pend [CORES];
   logic [LW-1:0]    core_pline[CORES];

   logic             in_range;
   logic             spend_q;
   logic             casc_hit;
   ack_path_e        path;
   logic [VEC_W-1:0] vec_nxt;

   assign in_range = (int'(req_num) < TOTAL);
   assign core_eoi[MASTER_ID] = eoi_master;
   assign core_eoi[SLAVE_ID]  = eoi_slave;

   for (genvar c = 0; c < CORES; c++) begin : g_core
      assign core_we[c] = req_valid && in_range && (int'(req_num[LW]) == c);
      casc_core #(.N(N), .LW(LW)) u_core (
         .clk      (clk),
         .rst_n    (rst_n),
         .lvl_we   (core_we[c]),
         .lvl_line (req_num[LW-1:0]),
         .lvl_val  (req_level),
         .inj      (core_inj[c]),
         .ack_en   (core_ack[c]),
         .ack_line (core_aline[c]),
         .eoi      (core_eoi[c]),
         .pend     (core_pend[c]),
         .pend_line(core_pline[c])
      );
   end

   // slave pending rise becomes a single edge on the cascade line
   always_comb begin
      core_inj[SLAVE_ID]  = '0;
      core_inj[MASTER_ID] = '0;
      if (core_pend[SLAVE_ID] && !spend_q) core_inj[MASTER_ID][CASC_LINE] = 1'b1;
   end

   always_comb begin
      casc_hit = core_pend[MASTER_ID] && (int'(core_pline[MASTER_ID]) == CASC_LINE);
      core_ack[MASTER_ID]   = inta && core_pend[MASTER_ID];
      core_aline[MASTER_ID] = core_pline[MASTER_ID];
      core_ack[SLAVE_ID]    = inta && casc_hit && core_pend[SLAVE_ID];
      core_aline[SLAVE_ID]  = core_pline[SLAVE_ID];
      if (!core_pend[MASTER_ID])     path = PATH_MSPUR;
      else if (!casc_hit)            path = PATH_LOCAL;
      else if (core_pend[SLAVE_ID])  path = PATH_CASC;
      else                           path = PATH_SSPUR;
      case (path)
         PATH_MSPUR: vec_nxt = MBASE + SPUR_OFS;
         PATH_LOCAL: vec_nxt = MBASE + VEC_W'(core_pline[MASTER_ID]);
         PATH_CASC:  vec_nxt = SBASE + VEC_W'(core_pline[SLAVE_ID]);
         default:    vec_nxt = SBASE + SPUR_OFS;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         spend_q   <= 1'b0;
         vec_valid <= 1'b0;
         vector    <= '0;
      end else begin
         spend_q   <= core_pend[SLAVE_ID];
         vec_valid <= inta;
         if (inta) vector <= vec_nxt;
      end
   end

   assign int_out = core_pend[MASTER_ID];

   p_vec_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      inta |=> vec_valid);
   p_vec_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !inta |=> !vec_valid);
   p_master_spur_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && !core_pend[MASTER_ID]) |=> (vector == MBASE + SPUR_OFS));
   p_casc_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && casc_hit && core_pend[SLAVE_ID])
      |=> (vector == SBASE + VEC_W'($past(core_pline[SLAVE_ID]))));
   p_slave_spur_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && casc_hit && !core_pend[SLAVE_ID]) |=> (vector == SBASE + SPUR_OFS));
   p_fwd_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (core_pend[SLAVE_ID] && spend_q) |-> (core_inj[MASTER_ID] == '0));
endmodule

// File: tb/casc_intc_tb.sv
module casc_intc_tb;
   localparam int CLK_PERIOD = 10;
   localparam int MB = 32'h20;
   localparam int SB = 32'h28;

   logic       clk = 0, rst_n = 0;
   logic       req_valid = 0, req_level = 0, inta = 0, eoi_master = 0, eoi_slave = 0;
   logic [4:0] req_num = '0;
   logic       int_out, vec_valid;
   logic [7:0] vector;

   int checks = 0, fails = 0;
   bit done = 0;

   // behavioural model state
   logic [7:0] m_lvl[2], m_irr[2], m_isr[2];
   bit         m_sprev;
   bit         e_vv;
   int         e_vec;
   string      e_tag;

   casc_intc u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_num(req_num),
      .req_level(req_level), .inta(inta), .eoi_master(eoi_master),
      .eoi_slave(eoi_slave), .int_out(int_out), .vec_valid(vec_valid), .vector(vector)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic int lowest(input logic [7:0] v);
      for (int i = 0; i < 8; i++) if (v[i]) return i;
      return 8;
   endfunction

   function automatic bit pend_of(input int c);
      return (lowest(m_irr[c]) < lowest(m_isr[c]));
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // compare then advance model with the inputs the DUT samples next edge
   always @(negedge clk) if (!done) begin
      chk(int_out == pend_of(0), "R3 int_out", int_out, pend_of(0));
      chk(vec_valid == e_vv, "R9 vec_valid", vec_valid, e_vv);
      if (e_vv) chk(vector == e_vec[7:0], e_tag, vector, e_vec);
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin m_lvl[c] = 0; m_irr[c] = 0; m_isr[c] = 0; end
         m_sprev = 0; e_vv = 0;
      end else begin
         logic [7:0] setb[2], clrb[2], eob[2];
         bit mp, sp; int ml, sl;
         mp = pend_of(0); sp = pend_of(1);
         ml = lowest(m_irr[0]); sl = lowest(m_irr[1]);
         for (int c = 0; c < 2; c++) begin setb[c] = 0; clrb[c] = 0; eob[c] = 0; end
         if (req_valid && req_num < 16) begin
            if (req_level && !m_lvl[req_num/8][req_num%8]) setb[req_num/8][req_num%8] = 1;
            m_lvl[req_num/8][req_num%8] = req_level;
         end
         if (sp && !m_sprev) setb[0][2] = 1;
         m_sprev = sp;
         e_vv = inta;
         if (inta) begin
            if (!mp) begin e_vec = MB + 7; e_tag = "R8 master spurious"; end
            else if (ml != 2) begin clrb[0][ml] = 1; e_vec = MB + ml; e_tag = "R5 local vector"; end
            else if (sp) begin
               clrb[0][2] = 1; clrb[1][sl] = 1; e_vec = SB + sl; e_tag = "R6 cascade vector";
            end else begin clrb[0][2] = 1; e_vec = SB + 7; e_tag = "R7 slave spurious"; end
         end
         if (eoi_master && m_isr[0] != 0) eob[0][lowest(m_isr[0])] = 1;
         if (eoi_slave && m_isr[1] != 0) eob[1][lowest(m_isr[1])] = 1;
         for (int c = 0; c < 2; c++) begin
            m_irr[c] = (m_irr[c] & ~clrb[c]) | setb[c];
            m_isr[c] = (m_isr[c] & ~eob[c]) | clrb[c];
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic req(input int num, input bit lvl);
      @(posedge clk); #1;
      req_valid = 1; req_num = 5'(num); req_level = lvl;
      @(posedge clk); #1;
      req_valid = 0;
   endtask

   task automatic ack(input int exp, input string tag);
      @(posedge clk); #1; inta = 1;
      @(posedge clk); #1; inta = 0;
      chk(vec_valid == 1 && vector == exp[7:0], tag, vector, exp);
   endtask

   task automatic eoi(input bit slave);
      @(posedge clk); #1;
      if (slave) eoi_slave = 1; else eoi_master = 1;
      @(posedge clk); #1;
      eoi_slave = 0; eoi_master = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      idle(3);
      chk(int_out == 0 && vec_valid == 0, "R3 reset state", int_out, 0);
      rst_n = 1;
      idle(2);
      ack(MB + 7, "R8 empty acknowledge");
      req(5, 1); idle(1);
      chk(int_out == 1, "R1 master line 5 raises int_out", int_out, 1);
      ack(MB + 5, "R1 R5 line 5 vector");
      chk(int_out == 0, "R9 int_out drops after acknowledge", int_out, 0);
      eoi(0);
      req(5, 1); idle(2);
      chk(int_out == 0, "R10 held level does not re-request", int_out, 0);
      req(5, 0); req(5, 1); idle(1);
      chk(int_out == 1, "R10 new rising level requests", int_out, 1);
      ack(MB + 5, "R10 relatched vector"); eoi(0);
      req(20, 1); req(31, 1); idle(3);
      chk(int_out == 0, "R2 out-of-range ignored", int_out, 0);
      ack(MB + 7, "R2 no state from out-of-range");
      req(11, 1); idle(3);
      chk(int_out == 1, "R4 slave request forwarded", int_out, 1);
      ack(SB + 3, "R6 cascaded line 11");
      eoi(1); eoi(0); idle(2);
      chk(int_out == 0, "R4 forwarded edge consumed", int_out, 0);
      req(2, 1); idle(1);
      ack(SB + 7, "R7 slave spurious");
      eoi(0);
      req(6, 1); req(3, 1); idle(1);
      ack(MB + 3, "R12 lower line first");
      chk(int_out == 0, "R12 in-service line 3 blocks line 6", int_out, 0);
      eoi(0); idle(1);
      chk(int_out == 1, "R11 end-of-service releases line 6", int_out, 1);
      ack(MB + 6, "R11 line 6 after release"); eoi(0);
      req(8, 1); idle(3);
      ack(SB + 0, "R6 cascaded line 8");
      eoi(1); req(9, 1); idle(3);
      chk(int_out == 0, "R4 forward held by in-service line 2", int_out, 0);
      eoi(0); idle(1);
      chk(int_out == 1, "R4 forwarded edge visible after release", int_out, 1);
      ack(SB + 1, "R6 cascaded line 9");
      eoi(1); eoi(0); idle(3);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule